// File: doc/BRIEF.md
# Dual-Channel Bus-Master Disk Controller Register Block

This block is the I/O-mapped register file of a two-channel bus-master disk controller. It decodes a 16-byte region that holds two 8-byte channel slices. Each slice has a four-byte control window that holds a command byte, a view of the shared mode byte, a status byte and a timing byte. Each slice also has a 32-bit descriptor-table pointer. Software uses the command byte to start a channel and pick its transfer direction, polls or acknowledges the status byte, and tunes the timing byte. The DMA engine outside the block reads the start and direction bits from the block's outputs.

The two drive interrupt levels are copied every cycle into pending bits of the shared mode byte. Software can mask each channel with a block bit in the same byte. A single active-high interrupt line is formed from the pending bits and block bits of both channels. The block does not contain the data mover, the drive protocol or configuration space.

Top module: `idebm_regblock`

## Requirements
- R1: Channel i owns offsets 8*i to 8*i+7. Its control window is at 8*i+0 (command), 8*i+1 (shared mode), 8*i+2 (status) and 8*i+3 (timing), and its pointer is at 8*i+4. Each channel has its own timing byte, and the two timing bytes never alias.
- R2: A synchronous active-high reset clears the command, status, timing, mode and pointer registers. After reset the interrupt output and both start outputs are low.
- R3: The interrupt output is (mode[2] AND NOT mode[4]) OR (mode[3] AND NOT mode[5]), and it is recomputed in the same cycle the mode byte changes.
- R4: At every clock edge, mode bit 2 takes drive level 0 and mode bit 3 takes drive level 1, so each pending bit follows its level one cycle later and does not latch an edge.
- R5: A byte write to mode offset 1 of either slice changes only mode bits 5:4, which are the block bits for channel 0 and channel 1. All other mode bits keep their values, and bits 7:6 and 1:0 always read 0.
- R6: A byte write to status loads bits 6:5 from the data and leaves bit 0 unchanged. Bits 2:1 are cleared where the data has a 1 and kept where it has a 0. Bits 7, 4 and 3 read 0.
- R7: Only command bit 0 (start) and bit 3 (direction) are stored, and the other bits read 0. The stored bits drive the cmd_start and cmd_dir outputs. A command write with data bit 0 = 1 sets status bit 0, and one with data bit 0 = 0 clears it.
- R8: A control-window access whose size code is not byte (size code 0 = byte, 1 = two bytes, 2 or 3 = four bytes) reads all ones at the access width (0xFFFF or 0xFFFFFFFF), and a write of that kind changes nothing.
- R9: The pointer accepts only four-byte accesses at offset 8*i+4. A write stores the data with its low ADR_ALIGN_BITS bits forced to 0. Any other access inside the pointer slot reads all ones at the access width and, as a write, changes nothing.
- R10: A rising edge of a channel's drive level sets that channel's status bit 2, and this set takes priority over a clear by a status write in the same cycle.
- R11: Read data is registered. The value addressed while bus_rd is high appears on bus_rdata after the next clock edge and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset within the 16-byte region |
| bus_size | input | 2 | Access size code: 0 byte, 1 two bytes, 2/3 four bytes |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| drv_irq | input | 2 | Drive interrupt level per channel |
| irq_out | output | 1 | Combined active-high interrupt |
| cmd_start | output | 2 | Start bit per channel |
| cmd_dir | output | 2 | Direction bit per channel |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, two channels and ADR_ALIGN_BITS = 2. This exercises the all-ones patterns at every access width, the dropping of the two low pointer bits, and both slices of the shared mode byte. With two channels, every combination of pending and block bits can be reached, including the case where one channel holds the line high while the other is masked. It also reaches the cycle where a drive edge meets a status acknowledge.

// File: rtl/idebm_pkg.sv
package idebm_pkg;
    localparam int NCH  = 2;
    localparam int DW   = 32;
    localparam int BW   = 8;
    localparam int AW   = 4;
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        OFF_CMD  = 2'd0,
        OFF_MODE = 2'd1,
        OFF_STS  = 2'd2,
        OFF_TIM  = 2'd3
    } ctl_off_e;

    localparam int MODE_PEND_LSB = 2;
    localparam int MODE_BLK_LSB  = 4;
    localparam int CMD_START_BIT = 0;
    localparam int CMD_DIR_BIT   = 3;
    localparam int STS_ACT_BIT   = 0;
    localparam int STS_IRQ_BIT   = 2;
    localparam logic [BW-1:0] CMD_KEEP = 8'h09;
    localparam logic [BW-1:0] STS_RW   = 8'h60;
    localparam logic [BW-1:0] STS_W1C  = 8'h06;

    typedef struct packed {
        logic cmd;
        logic sts;
        logic tim;
        logic adr;
    } chan_we_t;

    function automatic logic [DW-1:0] ones_for(acc_size_e sz);
        case (sz)
            SZ_BYTE: ones_for = {{(DW-8){1'b0}},  8'hFF};
            SZ_HALF: ones_for = {{(DW-16){1'b0}}, 16'hFFFF};
            default: ones_for = '1;
        endcase
    endfunction
endpackage

// File: rtl/idebm_decode.sv
module idebm_decode
    import idebm_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  acc_size_e     size,
    input  logic          wr,
    output chan_we_t      ch_we [NCH],
    output logic          mode_we
);
    logic     in_ctl;
    ctl_off_e off;
    logic     byte_acc;

    assign in_ctl   = !addr[2];
    assign off      = ctl_off_e'(addr[1:0]);
    assign byte_acc = (size == SZ_BYTE);
    assign mode_we  = wr && in_ctl && byte_acc && (off == OFF_MODE);

    for (genvar i = 0; i < NCH; i++) begin : g_sel
        logic hit;
        assign hit           = wr && (addr[AW-1:3] == i[AW-4:0]);
        assign ch_we[i].cmd  = hit && in_ctl && byte_acc && (off == OFF_CMD);
        assign ch_we[i].sts  = hit && in_ctl && byte_acc && (off == OFF_STS);
        assign ch_we[i].tim  = hit && in_ctl && byte_acc && (off == OFF_TIM);
        assign ch_we[i].adr  = hit && !in_ctl && (addr[1:0] == 2'b00) &&
                               (size == SZ_WORD || size == SZ_WIDE);
    end
endmodule

// File: rtl/idebm_chan.sv
module idebm_chan
    import idebm_pkg::*;
#(
    parameter int ALIGN = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  chan_we_t      we,
    input  logic [DW-1:0] wdata,
    input  logic          drv_lvl,
    output logic [BW-1:0] cmd_q,
    output logic [BW-1:0] sts_q,
    output logic [BW-1:0] tim_q,
    output logic [DW-1:0] adr_q
);
    localparam logic [DW-1:0] ADR_MASK = ~((DW'(1) << ALIGN) - DW'(1));

    logic [BW-1:0] wbyte;
    logic [BW-1:0] sts_n;
    logic          drv_d;

    assign wbyte = wdata[BW-1:0];

    always_comb begin
        sts_n = sts_q;
        if (we.sts) begin
            sts_n = (wbyte & STS_RW) | (sts_q & (BW'(1) << STS_ACT_BIT)) |
                    (sts_q & ~wbyte & STS_W1C);
        end
        if (we.cmd) begin
            sts_n[STS_ACT_BIT] = wbyte[CMD_START_BIT];
        end
        if (drv_lvl && !drv_d) begin
            sts_n[STS_IRQ_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            sts_q <= '0;
            tim_q <= '0;
            adr_q <= '0;
            drv_d <= 1'b0;
        end else begin
            drv_d <= drv_lvl;
            sts_q <= sts_n;
            if (we.cmd) cmd_q <= wbyte & CMD_KEEP;
            if (we.tim) tim_q <= wbyte;
            if (we.adr) adr_q <= wdata & ADR_MASK;
        end
    end
endmodule

// File: rtl/idebm_mode.sv
module idebm_mode
    import idebm_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [BW-1:0]  wbyte,
    input  logic [NCH-1:0] drv_lvl,
    output logic [BW-1:0]  mode_q,
    output logic           irq
);
    logic [NCH-1:0] term;
    logic [BW-1:0]  mode_n;

    always_comb begin
        mode_n = mode_q;
        for (int i = 0; i < NCH; i++) begin
            mode_n[MODE_PEND_LSB+i] = drv_lvl[i];
            if (we) mode_n[MODE_BLK_LSB+i] = wbyte[MODE_BLK_LSB+i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= '0;
        else     mode_q <= mode_n;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_term
        assign term[i] = mode_q[MODE_PEND_LSB+i] && !mode_q[MODE_BLK_LSB+i];
    end

    assign irq = |term;
endmodule

// File: rtl/idebm_regblock.sv
module idebm_regblock
    import idebm_pkg::*;
#(
    parameter int ADR_ALIGN_BITS = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  bus_addr,
    input  logic [1:0]     bus_size,
    input  logic [DW-1:0]  bus_wdata,
    input  logic           bus_wr,
    input  logic           bus_rd,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] drv_irq,
    output logic           irq_out,
    output logic [NCH-1:0] cmd_start,
    output logic [NCH-1:0] cmd_dir
);
    acc_size_e              size;
    chan_we_t               ch_we [NCH];
    logic                   mode_we;
    logic [BW-1:0]          mode_q;
    logic [NCH-1:0][BW-1:0] cmd_pk;
    logic [NCH-1:0][BW-1:0] sts_pk;
    logic [NCH-1:0][BW-1:0] tim_pk;
    logic [NCH-1:0][DW-1:0] adr_pk;
    logic [DW-1:0]          rd_val;
    logic [CH_W-1:0]        ch;

    assign size = acc_size_e'(bus_size);
    assign ch   = bus_addr[3 +: CH_W];

    idebm_decode u_dec (
        .addr    (bus_addr),
        .size    (size),
        .wr      (bus_wr),
        .ch_we   (ch_we),
        .mode_we (mode_we)
    );

    idebm_mode u_mode (
        .clk     (clk),
        .rst     (rst),
        .we      (mode_we),
        .wbyte   (bus_wdata[BW-1:0]),
        .drv_lvl (drv_irq),
        .mode_q  (mode_q),
        .irq     (irq_out)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        idebm_chan #(.ALIGN(ADR_ALIGN_BITS)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .we      (ch_we[i]),
            .wdata   (bus_wdata),
            .drv_lvl (drv_irq[i]),
            .cmd_q   (cmd_pk[i]),
            .sts_q   (sts_pk[i]),
            .tim_q   (tim_pk[i]),
            .adr_q   (adr_pk[i])
        );
        assign cmd_start[i] = cmd_pk[i][CMD_START_BIT];
        assign cmd_dir[i]   = cmd_pk[i][CMD_DIR_BIT];
    end

    always_comb begin
        rd_val = ones_for(size);
        if (!bus_addr[2] && size == SZ_BYTE) begin
            case (ctl_off_e'(bus_addr[1:0]))
                OFF_CMD:  rd_val = DW'(cmd_pk[ch]);
                OFF_MODE: rd_val = DW'(mode_q);
                OFF_STS:  rd_val = DW'(sts_pk[ch]);
                default:  rd_val = DW'(tim_pk[ch]);
            endcase
        end else if (bus_addr[2] && bus_addr[1:0] == 2'b00 &&
                     (size == SZ_WORD || size == SZ_WIDE)) begin
            rd_val = adr_pk[ch];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end
endmodule

// File: rtl/idebm_checker.sv
module idebm_checker
    import idebm_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   bus_wr,
    input logic [1:0]             bus_size,
    input logic [NCH-1:0]         drv_irq,
    input logic                   irq_out,
    input logic [NCH-1:0]         cmd_start,
    input logic [BW-1:0]          mode_q,
    input logic [NCH-1:0][BW-1:0] sts_pk,
    input logic [NCH-1:0][BW-1:0] tim_pk
);
    logic rst_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            a_r2_reset_clears: assert (!irq_out && cmd_start == '0 && mode_q == '0);
        end
    end

    a_r4_pend0_follows: assert property (@(posedge clk) disable iff (rst)
        !rst |=> mode_q[MODE_PEND_LSB] == $past(drv_irq[0]));
    a_r4_pend1_follows: assert property (@(posedge clk) disable iff (rst)
        !rst |=> mode_q[MODE_PEND_LSB+1] == $past(drv_irq[1]));
    a_r3_irq_needs_level: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> $past(drv_irq) != '0);
    a_r5_block_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(mode_q[MODE_BLK_LSB +: NCH]));
    a_r7_start0_active: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_start[0]) |-> sts_pk[0][STS_ACT_BIT]);
    a_r7_start1_active: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_start[1]) |-> sts_pk[1][STS_ACT_BIT]);
    a_r8_wide_wr_timing: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_size != 2'd0) |=> $stable(tim_pk));
    a_r6_rw_bits_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> ($stable(sts_pk[0][6:5]) && $stable(sts_pk[1][6:5])));
endmodule

bind idebm_regblock idebm_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_size  (bus_size),
    .drv_irq   (drv_irq),
    .irq_out   (irq_out),
    .cmd_start (cmd_start),
    .mode_q    (mode_q),
    .sts_pk    (sts_pk),
    .tim_pk    (tim_pk)
);

// File: tb/test_idebm_regblock.sv
module test_idebm_regblock;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [1:0]  drv_irq = '0;
    logic        irq_out;
    logic [1:0]  cmd_start;
    logic [1:0]  cmd_dir;

    int compared = 0;
    int mismatched = 0;
    logic issued = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    idebm_regblock i_idebm_regblock (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .drv_irq(drv_irq), .irq_out(irq_out),
        .cmd_start(cmd_start), .cmd_dir(cmd_dir)
    );

    // monitor: a read issued at a posedge shows its data by the next negedge
    always @(posedge clk) issued <= bus_rd;

    always @(negedge clk) begin
        if (issued) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compared++;
            if (bus_rdata !== e) begin
                mismatched++;
                $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = s; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] s,
                      input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr = a; bus_size = s; bus_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
        compared++;
        if (act !== e) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", t, act, e);
        end
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        // R2 reset state
        chk("R2 irq after reset", 32'(irq_out), 0);
        chk("R2 start after reset", 32'(cmd_start), 0);
        rd(4'd0, 2'd0, 32'h0, "R2 cmd0");
        rd(4'd1, 2'd0, 32'h0, "R2 mode");
        rd(4'd10, 2'd0, 32'h0, "R2 sts1");
        rd(4'd12, 2'd2, 32'h0, "R2 ptr1");

        // R1 timing bytes per slice, R11 read data held
        wr(4'd3, 2'd0, 32'h5A);
        wr(4'd11, 2'd0, 32'hA5);
        rd(4'd3, 2'd0, 32'h5A, "R1 tim0");
        rd(4'd11, 2'd0, 32'hA5, "R1 tim1");
        step();
        chk("R11 rdata held", bus_rdata, 32'hA5);

        // R8 wide control accesses
        wr(4'd3, 2'd1, 32'h1234);
        rd(4'd3, 2'd0, 32'h5A, "R8 wide write ignored");
        rd(4'd0, 2'd1, 32'h0000FFFF, "R8 half read");
        rd(4'd8, 2'd2, 32'hFFFFFFFF, "R8 word read");

        // R9 pointer
        wr(4'd12, 2'd2, 32'h12345677);
        rd(4'd12, 2'd2, 32'h12345674, "R9 ptr1 aligned");
        rd(4'd4, 2'd2, 32'h0, "R9 ptr0 untouched");
        rd(4'd4, 2'd0, 32'hFF, "R9 byte read ones");
        wr(4'd4, 2'd0, 32'hFF);
        rd(4'd4, 2'd2, 32'h0, "R9 byte write ignored");

        // R7 command
        wr(4'd0, 2'd0, 32'h09);
        chk("R7 start0", 32'(cmd_start), 32'h1);
        chk("R7 dir0", 32'(cmd_dir), 32'h1);
        rd(4'd2, 2'd0, 32'h01, "R7 active set");
        wr(4'd0, 2'd0, 32'hFF);
        rd(4'd0, 2'd0, 32'h09, "R7 unused bits zero");
        wr(4'd0, 2'd0, 32'h00);
        chk("R7 stop", 32'(cmd_start), 0);
        rd(4'd2, 2'd0, 32'h00, "R7 active cleared");
        wr(4'd0, 2'd0, 32'h01);

        // R4/R10/R3 drive level 0
        @(negedge clk); drv_irq = 2'b01;
        step();
        chk("R3 irq from ch0", 32'(irq_out), 1);
        rd(4'd1, 2'd0, 32'h04, "R4 pend0");
        rd(4'd2, 2'd0, 32'h05, "R10 sts irq bit");

        // R6 status write
        wr(4'd2, 2'd0, 32'h60);
        rd(4'd2, 2'd0, 32'h65, "R6 rw set w1c kept");
        wr(4'd2, 2'd0, 32'h04);
        rd(4'd2, 2'd0, 32'h01, "R6 w1c clear");

        // R5 mode writes and R3 masking
        wr(4'd9, 2'd0, 32'hFF);
        rd(4'd1, 2'd0, 32'h34, "R5 only block bits");
        chk("R3 ch0 blocked", 32'(irq_out), 0);
        wr(4'd1, 2'd0, 32'h20);
        chk("R3 ch0 unblocked", 32'(irq_out), 1);
        @(negedge clk); drv_irq = 2'b11;
        step();
        rd(4'd1, 2'd0, 32'h2C, "R4 pend1");
        rd(4'd10, 2'd0, 32'h04, "R10 ch1 sts irq bit");
        @(negedge clk); drv_irq = 2'b10;
        step();
        chk("R3 ch1 blocked ch0 idle", 32'(irq_out), 0);
        rd(4'd1, 2'd0, 32'h28, "R4 pend0 follows low");
        wr(4'd1, 2'd0, 32'h00);
        chk("R3 ch1 unblocked", 32'(irq_out), 1);

        // R10 set wins over same-cycle clear on ch0
        @(negedge clk);
        bus_addr = 4'd2; bus_size = 2'd0; bus_wdata = 32'h04; bus_wr = 1'b1;
        drv_irq = 2'b11;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(4'd2, 2'd0, 32'h05, "R10 set beats clear");
        @(negedge clk); drv_irq = 2'b00;
        step();
        chk("R4 all low irq", 32'(irq_out), 0);

        // R2 mid-run reset
        wr(4'd8, 2'd0, 32'h01);
        wr(4'd1, 2'd0, 32'h30);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R2 start cleared", 32'(cmd_start), 0);
        rd(4'd1, 2'd0, 32'h00, "R2 mode cleared");
        rd(4'd3, 2'd0, 32'h00, "R2 tim cleared");
        rd(4'd12, 2'd2, 32'h00, "R2 ptr cleared");

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule